// File: doc/BRIEF.md
# Signed-Digit Fraction Divider

This block divides one signed fixed-point fraction by another. It works one step per clock. Each step doubles the partial remainder and picks a quotient digit of -1, 0 or +1 by looking only at the four leading bits of that doubled value. It then subtracts the divisor, adds it, or leaves the value alone. A negative partial remainder is never restored. The sign of the next digit takes care of it.

Each pair of signed binary digits is folded into one radix-4 digit between -3 and +3. The digit is shown on a small output stream as it forms. It is also split into a positive-magnitude vector and a negative-magnitude vector. When the last step is done, one subtraction turns the redundant quotient into ordinary two's complement. A correction then gives the remainder the sign of the dividend and keeps its magnitude below the divisor.

A divisor of zero raises an error flag and finishes at once. Exponent handling and rounding belong to the surrounding floating-point logic.

Top module: `srt_divider`

## Requirements
- R1: Digit selection uses T, the doubled partial remainder in units of 2^-(W-1). The digit is +1 when T >= 2^(W-2) (value one half). It is -1 when T < -2^(W-2). Otherwise it is 0.
- R2: The recurrence is nonrestoring. The next remainder is T minus digit times divisor, and the first partial remainder is the dividend. When |dividend| < divisor and the divisor lies in [1/2, 1), every partial remainder stays within plus or minus the divisor.
- R3: Digits are paired in order of generation, most significant first. Each pair (a, b) gives radix-4 digit 2a+b in the range -3..+3. It is shown on `dig` as a 3-bit two's complement value, with `dig_vld` high for exactly one cycle per pair. There are (W-1)/2 such cycles per division.
- R4: `quotient` is a W-bit two's complement integer Q and `remainder` is a W-bit two's complement integer R. They satisfy dividend * 2^(W-1) = Q * divisor + R.
- R5: After correction, R is zero or has the sign of the dividend, and |R| < divisor. A raw final remainder of the wrong sign is moved by one divisor, and Q moves by one in the matching direction. A raw remainder equal to minus the divisor with a negative dividend is also moved by one divisor.
- R6: `busy` rises in the cycle after `start` is accepted. For a nonzero divisor, `done` is a one-cycle pulse in the cycle after W edges following the accepting edge. `busy` falls in that same cycle.
- R7: `start` is ignored while `busy` is high. Operands presented then do not change the result of the division in progress.
- R8: A divisor of zero sets `div_zero` and returns Q = 0 and R = 0. `done` pulses in the cycle after the second edge, counting from the accepting edge. The flag holds until the next accepted start.
- R9: After reset, `busy`, `done`, `dig_vld` and `div_zero` are low, and `quotient` and `remainder` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division when idle |
| dividend | input | W | Signed fraction, magnitude below the divisor |
| divisor | input | W | Positive fraction in [1/2, 1), or zero |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last division had a zero divisor |
| quotient | output | W | Two's complement quotient, scale 2^-(W-1) |
| remainder | output | W | Corrected remainder, see R4 |
| dig_vld | output | 1 | A radix-4 quotient digit is on `dig` |
| dig | output | 3 | Signed radix-4 digit, -3..+3 |

## Verification
The hardest state to reach is the exact-boundary remainder. In that state a partial remainder sits at exactly minus the divisor, which sends a long run of -1 digits into the final correction with a negative dividend. That path of R5 is not hit by random operands. The stimulus reaches it with a dividend of exactly minus half of the smallest normalized divisor, and it pairs that case with the positive mirror. The stimulus also covers the extreme divisors, dividends one unit inside the divisor, and a second start pulse in the middle of a run. A zero divisor is followed by an ordinary division to confirm that the error flag clears.

// File: rtl/srt_div_pkg.sv
package srt_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_FIN  = 2'd2
    } st_e;

    // signed binary quotient digit, two's complement in two bits
    typedef logic signed [1:0] sdig_t;

    localparam sdig_t SD_POS  = 2'sb01;
    localparam sdig_t SD_ZERO = 2'sb00;
    localparam sdig_t SD_NEG  = 2'sb11;

endpackage

// File: rtl/srt_qsel.sv
module srt_qsel
    import srt_div_pkg::*;
(
    input  logic signed [3:0] est,
    output sdig_t             qd
);
    // est = floor(2r / 2^(W-2)); the comparisons below are exact
    always_comb begin
        if (est >= 4'sd1) begin
            qd = SD_POS;
        end else if (est <= -4'sd2) begin
            qd = SD_NEG;
        end else begin
            qd = SD_ZERO;
        end
    end
endmodule

// File: rtl/srt_r4pack.sv
module srt_r4pack
    import srt_div_pkg::*;
(
    input  sdig_t             hi,
    input  sdig_t             lo,
    output logic signed [2:0] r4,
    output logic [1:0]        pmag,
    output logic [1:0]        nmag
);
    logic signed [2:0] h3;
    logic signed [2:0] l3;
    logic signed [2:0] neg3;

    always_comb begin
        h3   = {hi[1], hi};
        l3   = {lo[1], lo};
        r4   = (h3 <<< 1) + l3;
        neg3 = -r4;
        pmag = (r4 > 3'sd0) ? r4[1:0] : 2'd0;
        nmag = (r4 < 3'sd0) ? neg3[1:0] : 2'd0;
    end
endmodule

// File: rtl/srt_qconv.sv
module srt_qconv #(
    parameter int W  = 45,
    parameter int N  = W - 1,
    parameter int RW = W + 2
) (
    input  logic [N-1:0]         pos_mag,
    input  logic [N-1:0]         neg_mag,
    input  logic signed [RW-1:0] r_fin,
    input  logic [W-1:0]         dvs,
    input  logic                 x_neg,
    input  logic                 zero_div,
    output logic [W-1:0]         quo,
    output logic [W-1:0]         rem
);
    logic signed [W:0]    qraw;
    logic signed [W:0]    qfix;
    logic signed [RW-1:0] dext;
    logic signed [RW-1:0] rfix;

    always_comb begin
        qraw = $signed((W+1)'(pos_mag)) - $signed((W+1)'(neg_mag));
        dext = $signed(RW'(dvs));
        qfix = qraw;
        rfix = r_fin;
        if (!x_neg && r_fin < 0) begin
            rfix = r_fin + dext;
            qfix = qraw - 1;
        end else if (x_neg && r_fin > 0) begin
            rfix = r_fin - dext;
            qfix = qraw + 1;
        end else if (x_neg && r_fin == -dext) begin
            rfix = r_fin + dext;
            qfix = qraw - 1;
        end
        if (zero_div) begin
            qfix = '0;
            rfix = '0;
        end
        quo = qfix[W-1:0];
        rem = rfix[W-1:0];
    end
endmodule

// File: rtl/srt_divider.sv
module srt_divider
    import srt_div_pkg::*;
#(
    parameter int W = 45
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic         div_zero,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         dig_vld,
    output logic [2:0]   dig
);
    localparam int N  = W - 1;
    localparam int RW = W + 2;
    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        st_e                  st;
        logic [CW-1:0]        cnt;
        logic signed [RW-1:0] r;
        logic [W-1:0]         d;
        logic                 x_neg;
        sdig_t                held;
        logic [N-1:0]         pm;
        logic [N-1:0]         nm;
        logic [W-1:0]         quo;
        logic [W-1:0]         rem;
        logic                 done;
        logic                 dz;
        logic                 dvld;
        logic signed [2:0]    dig;
    } regs_t;

    regs_t q_q, q_d;

    logic signed [RW-1:0] tr;
    logic signed [RW-1:0] dext;
    logic signed [3:0]    est;
    sdig_t                qd;
    logic signed [2:0]    r4;
    logic [1:0]           pmag;
    logic [1:0]           nmag;
    logic [W-1:0]         cq;
    logic [W-1:0]         cr;

    always_comb begin
        tr   = q_q.r <<< 1;
        est  = tr[RW-1 -: 4];
        dext = $signed(RW'(q_q.d));
    end

    srt_qsel u_qsel (
        .est (est),
        .qd  (qd)
    );

    srt_r4pack u_pack (
        .hi   (q_q.held),
        .lo   (qd),
        .r4   (r4),
        .pmag (pmag),
        .nmag (nmag)
    );

    srt_qconv #(.W(W), .N(N), .RW(RW)) u_conv (
        .pos_mag  (q_q.pm),
        .neg_mag  (q_q.nm),
        .r_fin    (q_q.r),
        .dvs      (q_q.d),
        .x_neg    (q_q.x_neg),
        .zero_div (q_q.dz),
        .quo      (cq),
        .rem      (cr)
    );

    always_comb begin
        q_d      = q_q;
        q_d.done = 1'b0;
        q_d.dvld = 1'b0;
        unique case (q_q.st)
            ST_IDLE: begin
                if (start) begin
                    q_d.d     = divisor;
                    q_d.x_neg = dividend[W-1];
                    q_d.cnt   = '0;
                    q_d.pm    = '0;
                    q_d.nm    = '0;
                    q_d.held  = SD_ZERO;
                    if (divisor == '0) begin
                        q_d.dz = 1'b1;
                        q_d.r  = '0;
                        q_d.st = ST_FIN;
                    end else begin
                        q_d.dz = 1'b0;
                        q_d.r  = $signed({{2{dividend[W-1]}}, dividend});
                        q_d.st = ST_STEP;
                    end
                end
            end
            ST_STEP: begin
                if (qd == SD_POS) begin
                    q_d.r = tr - dext;
                end else if (qd == SD_NEG) begin
                    q_d.r = tr + dext;
                end else begin
                    q_d.r = tr;
                end
                q_d.cnt = q_q.cnt + 1'b1;
                if (!q_q.cnt[0]) begin
                    q_d.held = qd;
                end else begin
                    q_d.dvld = 1'b1;
                    q_d.dig  = r4;
                    q_d.pm   = {q_q.pm[N-3:0], pmag};
                    q_d.nm   = {q_q.nm[N-3:0], nmag};
                end
                if (q_q.cnt == CW'(N - 1)) begin
                    q_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                q_d.quo  = cq;
                q_d.rem  = cr;
                q_d.done = 1'b1;
                q_d.st   = ST_IDLE;
            end
            default: q_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{st: ST_IDLE, held: SD_ZERO, dig: 3'sd0, r: '0, default: '0};
        end else begin
            q_q <= q_d;
        end
    end

    assign busy      = (q_q.st != ST_IDLE);
    assign done      = q_q.done;
    assign div_zero  = q_q.dz;
    assign quotient  = q_q.quo;
    assign remainder = q_q.rem;
    assign dig_vld   = q_q.dvld;
    assign dig       = q_q.dig;

    // operand-contract flag used only to qualify the checks below
    logic                 ok_q;
    logic                 in_range;
    logic signed [RW-1:0] xs_in;
    logic signed [RW-1:0] ds_in;

    always_comb begin
        xs_in    = $signed({{2{dividend[W-1]}}, dividend});
        ds_in    = $signed(RW'(divisor));
        in_range = (xs_in < ds_in) && (xs_in > -ds_in) &&
                   !divisor[W-1] && divisor[W-2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q <= 1'b0;
        end else if (start && q_q.st == ST_IDLE) begin
            ok_q <= in_range;
        end
    end

    p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == ST_STEP && ok_q) |-> (q_q.r <= dext && q_q.r >= -dext));

    p_dig_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dig_vld |-> (dig != 3'b100));

    p_rem_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && ok_q) |-> (remainder == '0 || remainder[W-1] == q_q.x_neg));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_divisor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q_q.st != ST_FIN) |=> $stable(q_q.d));

    p_zero_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor == '0) |=> ##1 (done && div_zero));

endmodule

// File: tb/srt_divider_tb.sv
module srt_divider_tb;
    localparam int W = 45;
    localparam int N = W - 1;
    localparam longint HALF = longint'(1) <<< (W - 2);
    localparam longint DMIN = HALF;
    localparam longint DMAX = (longint'(1) <<< (W - 1)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic busy, done, div_zero, dig_vld;
    logic signed [W-1:0] quotient, remainder;
    logic signed [2:0] dig;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    srt_divider #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .div_zero(div_zero),
        .quotient(quotient), .remainder(remainder),
        .dig_vld(dig_vld), .dig(dig)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_div(input longint X, input longint D, input bit poke);
        longint r, qa, tr, rm, qm, lo_dig, a_dig;
        logic signed [127:0] lhs, rhs;
        longint qo, ro;
        r = X; qa = 0; a_dig = 0;
        @(negedge clk);
        dividend = X[W-1:0];
        divisor  = D[W-1:0];
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R6 busy after start", longint'(busy), 1);
        if (D == 0) begin
            @(negedge clk);
            chk(done == 1'b1, "R8 done after two edges", longint'(done), 1);
            chk(div_zero == 1'b1, "R8 flag", longint'(div_zero), 1);
            chk(quotient == '0 && remainder == '0, "R8 zero results",
                longint'(quotient), 0);
            chk(busy == 1'b0, "R8 busy low", longint'(busy), 0);
            @(negedge clk);
            chk(done == 1'b0, "R6 done one cycle", longint'(done), 0);
            return;
        end
        for (int k = 1; k <= N; k++) begin
            tr = 2 * r;
            if (tr >= HALF) lo_dig = 1;
            else if (tr < -HALF) lo_dig = -1;
            else lo_dig = 0;
            r  = tr - lo_dig * D;
            qa = 2 * qa + lo_dig;
            if (poke && k == 3) begin
                dividend = ~X[W-1:0];
                divisor  = DMIN[W-1:0];
                start    = 1'b1;
            end
            @(negedge clk);
            if (poke && k == 3) start = 1'b0;
            chk(busy == 1'b1 && done == 1'b0, "R6 busy during steps", longint'(busy), 1);
            chk(r <= D && r >= -D, "R2 model remainder bound", r, D);
            if (k % 2 == 0) begin
                chk(dig_vld == 1'b1, "R3 dig_vld on pair", longint'(dig_vld), 1);
                chk(longint'(dig) == 2 * a_dig + lo_dig, "R1 R3 radix-4 digit",
                    longint'(dig), 2 * a_dig + lo_dig);
            end else begin
                chk(dig_vld == 1'b0, "R3 dig_vld between pairs", longint'(dig_vld), 0);
                a_dig = lo_dig;
            end
        end
        rm = r; qm = qa;
        if (X >= 0 && rm < 0) begin rm = rm + D; qm = qm - 1; end
        else if (X < 0 && rm > 0) begin rm = rm - D; qm = qm + 1; end
        else if (X < 0 && rm == -D) begin rm = rm + D; qm = qm - 1; end
        @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R6 done pulse timing", longint'(done), 1);
        chk(div_zero == 1'b0, "R8 flag clear on normal divide", longint'(div_zero), 0);
        qo = longint'(quotient);
        ro = longint'(remainder);
        chk(qo == qm, "R4 quotient", qo, qm);
        chk(ro == rm, "R5 corrected remainder", ro, rm);
        lhs = 128'(X) <<< N;
        rhs = 128'(qo) * 128'(D) + 128'(ro);
        chk(lhs == rhs, "R4 Q*D+R identity", qo, qm);
        chk((ro < D) && (ro > -D), "R5 remainder magnitude", ro, D);
        chk(ro == 0 || ((ro < 0) == (X < 0)), "R5 remainder sign", ro, X);
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", longint'(done), 0);
        chk(dig_vld == 1'b0 && busy == 1'b0, "R7 no extra run after poke",
            longint'(busy), 0);
    endtask

    function automatic longint rnd(input longint lim);
        logic [63:0] u;
        u = {$urandom(), $urandom()};
        return longint'({2'b00, u[61:0]}) % lim;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        longint d, x;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && dig_vld == 0 && div_zero == 0, "R9 reset controls",
            longint'(busy), 0);
        chk(quotient == '0 && remainder == '0, "R9 reset data", longint'(quotient), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // exact half, both signs; negative one drives a remainder of minus the divisor
        do_div(DMIN / 2, DMIN, 1'b0);
        do_div(-(DMIN / 2), DMIN, 1'b0);
        do_div(0, DMAX, 1'b0);
        do_div(DMAX - 1, DMAX, 1'b0);
        do_div(-(DMAX - 1), DMAX, 1'b0);
        do_div(DMIN - 1, DMIN, 1'b0);
        do_div(-(DMIN - 1), DMIN, 1'b0);
        do_div(12345, DMIN + 777, 1'b1);
        do_div(-999999, DMAX - 5, 1'b1);
        do_div(-777, 0, 1'b0);
        do_div(DMIN / 3, DMIN + DMIN / 2, 1'b0);
        for (int i = 0; i < 30; i++) begin
            d = DMIN + rnd(DMIN);
            x = rnd(d);
            if (i % 2 == 1) x = -x;
            do_div(x, d, (i % 7) == 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule